// File: doc/BRIEF.md
# Codec Scratch Mailbox with Interrupt

This block passes a stream format from an audio codec front end to a host processor. The codec side has a write port onto two 32-bit scratch registers. Every codec write stores the data word and records an event in an interrupt status register. Two further event inputs, a content-protection request and a general scratch event, also record events in that register. The host sees status, mask, enable and both scratch words on a small register bus. A single registered interrupt line tells the host that an event needs attention.

Scratch register 0 holds a stream format word. Bit 30 is a valid flag and bits [15:0] are the format. The block decodes this word in hardware. It derives the sample rate from a base rate, a multiplier and a divisor. It derives the channel count from a 4-bit field. It then picks one of seven per-rate slots as a one-hot vector. When the valid flag is clear, or the rate has no slot, the audio enable output is low. The host can use the interrupt to reprogram the audio path, and downstream logic can use the decoded outputs directly.

Top module: `scratch_mailbox`

## Requirements
- R1: After reset the status, mask and enable registers and both scratch registers read as zero, and `irq` is low.
- R2: A codec write with `codecWrSel`=0 stores `codecWrData` in scratch 0 and sets status bit 0 at that clock edge. With `codecWrSel`=1 it stores the data in scratch 1 and sets status bit 1. Mask and enable have no effect on this.
- R3: `extEvent[0]` sets status bit 2 (content-protection request) and `extEvent[1]` sets status bit 3 (general scratch) at the clock edge where they are high.
- R4: A host write to the status address clears each status bit whose written bit is 1. Bits written as 0 are left unchanged.
- R5: If a set and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R6: `irq` is registered. It is high one clock after some status bit is 1 with both its mask bit and its enable bit at 1. Otherwise it is low.
- R7: The host address map is: 0 status, 1 mask, 2 enable, 3 scratch 0, 4 scratch 1. Any other address reads zero. Mask and enable store `hostWrData[3:0]`, and reads return them zero-extended.
- R8: The format field layout in scratch 0 is: bit 14 base select, bits [13:11] multiplier M, bits [10:8] divisor D. `sampleRate` = base × (M+1) / (D+1), truncated, with base 44100 when bit 14 is 1 and 48000 when it is 0.
- R9: `channelCount` equals scratch 0 bits [3:0] plus one.
- R10: `rateSlot` is one-hot, with bit 0..6 standing for 32000, 44100, 48000, 88200, 96000, 176400 and 192000. Any other rate gives `rateSlot`=0 and `rateSupported` low.
- R11: `streamValid` follows scratch 0 bit 30. `audioEnable` is high only when the stream is valid and the rate is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| codecWrEn | input | 1 | Codec scratch write strobe |
| codecWrSel | input | 1 | Target scratch register (0 or 1) |
| codecWrData | input | 32 | Codec write data |
| extEvent | input | 2 | Event pulses for status bits 3:2 |
| hostAddr | input | 3 | Host register address |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 4 | Host write data (status clear, mask, enable) |
| hostRdData | output | 32 | Host read data, combinational from address |
| irq | output | 1 | Registered interrupt |
| streamValid | output | 1 | Valid flag of scratch 0 |
| sampleRate | output | 19 | Decoded sample rate in Hz |
| channelCount | output | 5 | Decoded channel count |
| rateSlot | output | 7 | One-hot per-rate slot select |
| rateSupported | output | 1 | Decoded rate has a slot |
| audioEnable | output | 1 | Valid and supported stream |

## Verification
The in-line properties watch the event bookkeeping on every cycle. They check that a codec write or event pulse leaves its status bit set, that a clear without a competing set removes a bit, and that set wins over clear. They also check that the interrupt stays low while no source is both unmasked and enabled, that the slot vector never has more than one bit set, and that scratch 0 holds its value between writes. The actual decoded rates, the slot each rate lands on, the channel counts, the address map and the exact interrupt latency are fixed values. Only the bench's format-word table and its directed scenarios can show them.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int REG_W     = 32;
  localparam int SRC_N     = 4;
  localparam int EXT_N     = SRC_N - 2;
  localparam int SLOT_N    = 7;
  localparam int RATE_W    = 19;
  localparam int CHAN_W    = 4;
  localparam int ADDR_W    = 3;
  localparam int VALID_BIT = 30;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_SCR0   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SCR1   = 3'd4;

  // load strobes from control to datapath
  typedef struct packed {
    logic loadScr0;
    logic loadScr1;
  } mboxStrobe_t;

  // slot order is behavioural: slot index = position in this list
  function automatic logic [RATE_W-1:0] slotRate(input int idx);
    case (idx)
      0:       slotRate = RATE_W'(32000);
      1:       slotRate = RATE_W'(44100);
      2:       slotRate = RATE_W'(48000);
      3:       slotRate = RATE_W'(88200);
      4:       slotRate = RATE_W'(96000);
      5:       slotRate = RATE_W'(176400);
      default: slotRate = RATE_W'(192000);
    endcase
  endfunction
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              codecWrEn,
  input  logic              codecWrSel,
  input  logic [EXT_N-1:0]  extEvent,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [SRC_N-1:0]  hostWrData,
  input  logic [REG_W-1:0]  scr0Q,
  input  logic [REG_W-1:0]  scr1Q,
  output logic [REG_W-1:0]  hostRdData,
  output mboxStrobe_t       strobe,
  output logic              irq
);
  logic [SRC_N-1:0] statusQ, maskQ, enableQ;
  logic [SRC_N-1:0] setVec, clrVec, statusD;
  logic             irqQ;

  always_comb begin
    strobe.loadScr0 = codecWrEn && !codecWrSel;
    strobe.loadScr1 = codecWrEn && codecWrSel;
  end

  assign setVec  = {extEvent, strobe.loadScr1, strobe.loadScr0};
  assign clrVec  = (hostWrEn && hostAddr == ADDR_STATUS) ? hostWrData : '0;
  assign statusD = (statusQ & ~clrVec) | setVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      enableQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusD;
      if (hostWrEn && hostAddr == ADDR_MASK)   maskQ   <= hostWrData;
      if (hostWrEn && hostAddr == ADDR_ENABLE) enableQ <= hostWrData;
      irqQ <= |(statusQ & maskQ & enableQ);
    end
  end

  assign irq = irqQ;

  always_comb begin
    case (hostAddr)
      ADDR_STATUS: hostRdData = REG_W'(statusQ);
      ADDR_MASK:   hostRdData = REG_W'(maskQ);
      ADDR_ENABLE: hostRdData = REG_W'(enableQ);
      ADDR_SCR0:   hostRdData = scr0Q;
      ADDR_SCR1:   hostRdData = scr1Q;
      default:     hostRdData = '0;
    endcase
  end

  // R2: a codec write to scratch 0 always records its event
  a_r2_scr0_event: assert property (@(posedge clk) disable iff (!rstN)
    (codecWrEn && !codecWrSel) |=> statusQ[0]);

  // R3: external event pulse records status bit 2
  a_r3_ext_event: assert property (@(posedge clk) disable iff (!rstN)
    extEvent[0] |=> statusQ[2]);

  // R4: clear without a competing set removes the bit
  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == ADDR_STATUS && hostWrData[0] &&
     !(codecWrEn && !codecWrSel)) |=> !statusQ[0]);

  // R5: set beats clear on the same bit
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (codecWrEn && codecWrSel && hostWrEn && hostAddr == ADDR_STATUS &&
     hostWrData[1]) |=> statusQ[1]);

  // R6: no source both unmasked and enabled means no interrupt next cycle
  a_r6_gate: assert property (@(posedge clk) disable iff (!rstN)
    ((maskQ & enableQ) == '0) |=> !irq);
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrobe_t       strobe,
  input  logic [REG_W-1:0]  codecWrData,
  output logic [REG_W-1:0]  scr0Q,
  output logic [REG_W-1:0]  scr1Q,
  output logic              streamValid,
  output logic [RATE_W-1:0] sampleRate,
  output logic [CHAN_W:0]   channelCount,
  output logic [SLOT_N-1:0] rateSlot,
  output logic              rateSupported,
  output logic              audioEnable
);
  localparam int PROD_W = RATE_W + 4;

  logic              baseSel;
  logic [2:0]        mulF, divF;
  logic [CHAN_W-1:0] chanF;
  logic [RATE_W-1:0] baseRate;
  logic [PROD_W-1:0] prod, quot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scr0Q <= '0;
      scr1Q <= '0;
    end else begin
      if (strobe.loadScr0) scr0Q <= codecWrData;
      if (strobe.loadScr1) scr1Q <= codecWrData;
    end
  end

  assign baseSel  = scr0Q[14];
  assign mulF     = scr0Q[13:11];
  assign divF     = scr0Q[10:8];
  assign chanF    = scr0Q[CHAN_W-1:0];
  assign baseRate = baseSel ? RATE_W'(44100) : RATE_W'(48000);
  assign prod     = PROD_W'(baseRate) * PROD_W'({1'b0, mulF} + 4'd1);
  assign quot     = prod / PROD_W'({1'b0, divF} + 4'd1);

  assign sampleRate   = RATE_W'(quot);
  assign channelCount = {1'b0, chanF} + 1'b1;
  assign streamValid  = scr0Q[VALID_BIT];

  for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
    assign rateSlot[g] = (sampleRate == slotRate(g));
  end

  assign rateSupported = |rateSlot;
  assign audioEnable   = streamValid && rateSupported;

  // R10: at most one slot is ever selected
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rateSlot));

  // R11: writing a stopped stream disables audio on the next cycle
  a_r11_stop: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadScr0 && !codecWrData[VALID_BIT]) |=> !audioEnable);

  // R2: scratch 0 only changes on its own write
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadScr0 |=> $stable(scr0Q));
endmodule

// File: rtl/scratch_mailbox.sv
module scratch_mailbox
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              codecWrEn,
  input  logic              codecWrSel,
  input  logic [REG_W-1:0]  codecWrData,
  input  logic [EXT_N-1:0]  extEvent,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [SRC_N-1:0]  hostWrData,
  output logic [REG_W-1:0]  hostRdData,
  output logic              irq,
  output logic              streamValid,
  output logic [RATE_W-1:0] sampleRate,
  output logic [CHAN_W:0]   channelCount,
  output logic [SLOT_N-1:0] rateSlot,
  output logic              rateSupported,
  output logic              audioEnable
);
  mboxStrobe_t      strobe;
  logic [REG_W-1:0] scr0Q, scr1Q;

  mbox_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .codecWrEn(codecWrEn), .codecWrSel(codecWrSel), .extEvent(extEvent),
    .hostAddr(hostAddr), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .scr0Q(scr0Q), .scr1Q(scr1Q),
    .hostRdData(hostRdData), .strobe(strobe), .irq(irq)
  );

  mbox_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .codecWrData(codecWrData),
    .scr0Q(scr0Q), .scr1Q(scr1Q),
    .streamValid(streamValid), .sampleRate(sampleRate),
    .channelCount(channelCount), .rateSlot(rateSlot),
    .rateSupported(rateSupported), .audioEnable(audioEnable)
  );
endmodule

// File: tb/test_scratch_mailbox.sv
module test_scratch_mailbox;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        codecWrEn = 1'b0, codecWrSel = 1'b0;
  logic [31:0] codecWrData = '0;
  logic [1:0]  extEvent = '0;
  logic [2:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [3:0]  hostWrData = '0;
  logic [31:0] hostRdData;
  logic        irq, streamValid, rateSupported, audioEnable;
  logic [18:0] sampleRate;
  logic [4:0]  channelCount;
  logic [6:0]  rateSlot;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scratch_mailbox i_scratch_mailbox (
    .clk(clk), .rstN(rstN), .codecWrEn(codecWrEn), .codecWrSel(codecWrSel),
    .codecWrData(codecWrData), .extEvent(extEvent), .hostAddr(hostAddr),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .irq(irq), .streamValid(streamValid), .sampleRate(sampleRate),
    .channelCount(channelCount), .rateSlot(rateSlot),
    .rateSupported(rateSupported), .audioEnable(audioEnable)
  );

  localparam int NV = 10;
  localparam logic [15:0] V_FMT  [NV] = '{16'h0011, 16'h4013, 16'h0805, 16'h4801, 16'h1807,
                                          16'h5801, 16'h0A01, 16'h0101, 16'h4A00, 16'h380F};
  localparam int          V_RATE [NV] = '{48000, 44100, 96000, 88200, 192000,
                                          176400, 32000, 24000, 29400, 384000};
  localparam logic [6:0]  V_SLOT [NV] = '{7'h04, 7'h02, 7'h10, 7'h08, 7'h40,
                                          7'h20, 7'h01, 7'h00, 7'h00, 7'h00};
  localparam int          V_CH   [NV] = '{2, 4, 6, 2, 8, 2, 2, 2, 1, 16};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic codecWrite(input logic sel, input logic [31:0] data);
    @(negedge clk);
    codecWrEn = 1'b1; codecWrSel = sel; codecWrData = data;
    @(negedge clk);
    codecWrEn = 1'b0;
  endtask

  task automatic hostWrite(input logic [2:0] addr, input logic [3:0] data);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = addr; hostWrData = data;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] addr, output logic [31:0] data);
    hostAddr = addr;
    #1;
    data = hostRdData;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'd0);
    for (int a = 0; a < 5; a++) begin
      hostRead(3'(a), rd);
      check("R1 register reads zero", rd, 32'd0);
    end

    // vector table: R8 R9 R10 R11 R2
    for (int i = 0; i < NV; i++) begin
      codecWrite(1'b0, 32'h4000_0000 | {16'h0, V_FMT[i]});
      check("R8 sampleRate", {13'b0, sampleRate}, 32'(V_RATE[i]));
      check("R10 rateSlot", {25'b0, rateSlot}, {25'b0, V_SLOT[i]});
      check("R10 rateSupported", {31'b0, rateSupported}, {31'b0, V_SLOT[i] != 0});
      check("R9 channelCount", {27'b0, channelCount}, 32'(V_CH[i]));
      check("R11 audioEnable", {31'b0, audioEnable}, {31'b0, V_SLOT[i] != 0});
      hostRead(3'd3, rd);
      check("R7 scratch0 readback", rd, 32'h4000_0000 | {16'h0, V_FMT[i]});
      hostRead(3'd0, rd);
      check("R2 status bit0 set", rd, 32'h1);
      hostWrite(3'd0, 4'h1);
      hostRead(3'd0, rd);
      check("R4 status cleared", rd, 32'h0);
    end

    // R11 valid clear stops audio even with a supported format
    codecWrite(1'b0, 32'h0000_0011);
    check("R11 streamValid low", {31'b0, streamValid}, 32'd0);
    check("R11 audioEnable low", {31'b0, audioEnable}, 32'd0);
    hostWrite(3'd0, 4'hF);

    // R2 scratch 1 and R7 address map
    codecWrite(1'b1, 32'hDEAD_BEEF);
    hostRead(3'd4, rd);
    check("R2 scratch1 stored", rd, 32'hDEAD_BEEF);
    hostRead(3'd0, rd);
    check("R2 status bit1 only", rd, 32'h2);
    hostRead(3'd5, rd);
    check("R7 unmapped address", rd, 32'h0);

    // R6 masked source gives no irq
    hostWrite(3'd2, 4'hF);
    @(negedge clk);
    check("R6 masked irq low", {31'b0, irq}, 32'd0);
    hostWrite(3'd1, 4'h2);
    hostRead(3'd1, rd);
    check("R7 mask readback", rd, 32'h2);
    @(negedge clk);
    check("R6 irq high", {31'b0, irq}, 32'd1);
    hostWrite(3'd0, 4'h2);
    @(negedge clk);
    check("R6 irq low after clear", {31'b0, irq}, 32'd0);

    // R3 external events
    @(negedge clk);
    extEvent = 2'b01;
    @(negedge clk);
    extEvent = 2'b10;
    @(negedge clk);
    extEvent = 2'b00;
    hostRead(3'd0, rd);
    check("R3 ext events set bits 3:2", rd, 32'hC);

    // R4 selective clear: only bit 3 cleared
    hostWrite(3'd0, 4'h8);
    hostRead(3'd0, rd);
    check("R4 selective clear", rd, 32'h4);
    hostWrite(3'd0, 4'h4);

    // R5 set wins over clear in the same cycle
    @(negedge clk);
    codecWrEn = 1'b1; codecWrSel = 1'b0; codecWrData = 32'h1;
    hostWrEn = 1'b1; hostAddr = 3'd0; hostWrData = 4'h1;
    @(negedge clk);
    codecWrEn = 1'b0; hostWrEn = 1'b0;
    hostRead(3'd0, rd);
    check("R5 set wins", rd, 32'h1);

    // R1 reset again clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    hostRead(3'd3, rd);
    check("R1 scratch0 after reset", rd, 32'h0);
    hostRead(3'd2, rd);
    check("R1 enable after reset", rd, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule